// File: doc/BRIEF.md
# Embedded Sync Code Decoder

This block watches a YCrCb pixel stream for timing reference codes carried inside the data and turns them back into discrete timing signals. A code is four consecutive samples on the low byte lane of the bus. The first three are one byte of all ones followed by two bytes of all zeros. The fourth is a status byte whose bit 6 is the field flag, bit 5 is the vertical blanking flag and bit 4 tells an end-of-active-video code (1) from a start-of-active-video code (0). Bit 7 and bits 3..0 of the status byte carry no meaning for this block.

Two bus layouts are decoded. In the byte-multiplexed layout, samples arrive in the repeating order Cb, Y, Cr, Y. In the 16-bit layout, luma is on the upper byte and the chroma lane (bits 7..0) alternates Cb, Cr. In both layouts the leading all-ones byte is accepted only in a Cb position. Cb positions are counted from reset as sample index mod 4 = 0 in byte mode and mod 2 = 0 in 16-bit mode.

The pixel stream leaves the block four samples late. A qualifier marks the code samples as removed, and horizontal sync, vertical sync, field and active-video are aligned to the delayed stream. When neither embedded layout is selected, the sync outputs follow the external sync pins through the same delay.

Top module: `esync_decoder`

## Requirements
- R1: While `rst` is high, and for the first four samples after it falls, `pix_vld`, `hs_out`, `vs_out`, `field_out` and `act_out` are 0 and `pix_out` is 0.
- R2: `pix_out` in cycle k equals `pix_in` of cycle k-4 in every mode.
- R3: With `mode` 1 (byte-multiplexed) or 2 (16-bit), `pix_in[7:0]` = FFh in a Cb position, followed by 00h, 00h and any status byte, is a code. The four delayed code samples appear with `pix_vld` = 0, and every other sample appears with `pix_vld` = 1.
- R4: An FFh 00h 00h sequence whose FFh is not in a Cb position is not a code: it is passed with `pix_vld` = 1 and leaves the sync outputs unchanged.
- R5: An end-of-active-video code (status bit 4 = 1) sets `hs_out` to 1 and `vs_out` to status bit 5. Both take effect from the output cycle of the code's first sample.
- R6: Every code loads `field_out` with status bit 6 from the output cycle of its first sample. A start-of-active-video code (bit 4 = 0) clears `hs_out` and leaves `vs_out` unchanged.
- R7: `act_out` goes 0 with the first output sample of an end-of-active-video code. It goes 1 with the first output sample after a start-of-active-video code whose bit 5 is 0. When that sample is itself the start of an end-of-active-video code, the end code wins and `act_out` stays 0.
- R8: Status bits 7 and 3..0 have no effect on any output.
- R9: A preamble broken by a byte that does not match (FFh then non-zero, or FFh 00h then non-zero) strips nothing and changes no sync output. The breaking byte may itself start a new code if it is FFh in a Cb position.
- R10: With `mode` 0 or 3, no code is decoded. `hs_out` and `vs_out` equal `ext_hs` and `ext_vs` delayed four cycles, `field_out` is 0, and `act_out` is `pix_vld` and not (`hs_out` or `vs_out`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 external sync, 1 byte-multiplexed embedded, 2 16-bit embedded, 3 external |
| pix_in | input | 16 | Input pixel word; codes are read on bits 7..0 |
| ext_hs | input | 1 | External horizontal sync |
| ext_vs | input | 1 | External vertical sync |
| pix_out | output | 16 | Pixel word delayed four samples |
| pix_vld | output | 1 | 0 on samples removed as code words |
| hs_out | output | 1 | Regenerated horizontal sync |
| vs_out | output | 1 | Regenerated vertical sync |
| field_out | output | 1 | Field flag, 1 for the second field |
| act_out | output | 1 | Active-video flag |

## Verification
Two functions can land in the same clock edge: the delayed turn-on of active video after a start code, and the decode of an end code that follows it directly. The bench places a start code with bit 5 clear immediately before an end code in both bus layouts. It then expects `act_out` to stay low across the boundary, while the strip window is reloaded without a gap. Random streams full of misplaced and broken preambles also create this case, as well as code decodes that coincide with the last cycle of a strip window. Each output is judged every cycle against a bench model derived from the requirements.

// File: rtl/esync_pkg.sv
package esync_pkg;

    localparam int TRS_LEN = 4;
    localparam int LANE_W  = 8;
    localparam int PHASE_W = 2;

    localparam logic [LANE_W-1:0] TRS_ONES = '1;
    localparam logic [LANE_W-1:0] TRS_ZERO = '0;

    typedef enum logic [1:0] {
        SRC_EXTERNAL = 2'd0,
        SRC_EMB8     = 2'd1,
        SRC_EMB16    = 2'd2,
        SRC_SPARE    = 2'd3
    } sync_src_e;

    typedef enum logic [1:0] {
        DET_IDLE,
        DET_ONES,
        DET_ZERO1,
        DET_ZERO2
    } det_state_e;

    typedef struct packed {
        logic field;
        logic vblank;
        logic eav;
    } trs_status_t;

    function automatic trs_status_t decode_status(input logic [LANE_W-1:0] b);
        trs_status_t r;
        r.field  = b[6];
        r.vblank = b[5];
        r.eav    = b[4];
        return r;
    endfunction

    function automatic logic is_embedded(input sync_src_e s);
        return (s == SRC_EMB8) || (s == SRC_EMB16);
    endfunction

    function automatic logic [PHASE_W-1:0] cb_slot_mask(input sync_src_e s);
        return (s == SRC_EMB8) ? 2'b11 : 2'b01;
    endfunction

endpackage

// File: rtl/esync_slot_phase.sv
module esync_slot_phase
    import esync_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  sync_src_e src,
    output logic      cb_slot
);
    logic [PHASE_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst) phase <= '0;
        else     phase <= phase + 1'b1;
    end

    assign cb_slot = ((phase & cb_slot_mask(src)) == '0);
endmodule

// File: rtl/esync_trs_detect.sv
module esync_trs_detect
    import esync_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              cb_slot,
    input  logic [LANE_W-1:0] lane_byte,
    output logic              st_vld,
    output trs_status_t       st
);
    det_state_e state, nxt;
    logic       start;

    assign start = en && cb_slot && (lane_byte == TRS_ONES);
    assign st    = decode_status(lane_byte);

    always_comb begin
        nxt    = state;
        st_vld = 1'b0;
        unique case (state)
            DET_IDLE:  nxt = start ? DET_ONES : DET_IDLE;
            DET_ONES:  nxt = (lane_byte == TRS_ZERO) ? DET_ZERO1
                           : (start ? DET_ONES : DET_IDLE);
            DET_ZERO1: nxt = (lane_byte == TRS_ZERO) ? DET_ZERO2
                           : (start ? DET_ONES : DET_IDLE);
            DET_ZERO2: begin
                st_vld = en;
                nxt    = DET_IDLE;
            end
            default:   nxt = DET_IDLE;
        endcase
        if (!en) nxt = DET_IDLE;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= DET_IDLE;
        else     state <= nxt;
    end
endmodule

// File: rtl/esync_sync_gen.sv
module esync_sync_gen
    import esync_pkg::*;
#(
    parameter int LEN = TRS_LEN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        st_vld,
    input  trs_status_t st,
    output logic        hs,
    output logic        vs,
    output logic        fld,
    output logic        act,
    output logic        vld
);
    localparam int CNT_W = $clog2(LEN + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LEN);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(1);

    logic [CNT_W-1:0] kill_cnt;
    logic             act_pend;
    logic             win_end;

    assign win_end = (kill_cnt == CNT_LAST);
    assign vld     = (kill_cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_cnt <= CNT_LOAD;
            act_pend <= 1'b0;
            hs       <= 1'b0;
            vs       <= 1'b0;
            fld      <= 1'b0;
            act      <= 1'b0;
        end else begin
            if (st_vld)               kill_cnt <= CNT_LOAD;
            else if (kill_cnt != '0)  kill_cnt <= kill_cnt - 1'b1;

            if (st_vld) begin
                fld <= st.field;
                hs  <= st.eav;
                if (st.eav) vs <= st.vblank;
            end

            if (st_vld)       act_pend <= !st.eav && !st.vblank;
            else if (win_end) act_pend <= 1'b0;

            if (st_vld && st.eav)       act <= 1'b0;
            else if (act_pend && win_end) act <= 1'b1;
        end
    end
endmodule

// File: rtl/esync_delay.sv
module esync_delay #(
    parameter int W     = 18,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= din;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign dout = stage[DEPTH-1];
endmodule

// File: rtl/esync_decoder.sv
module esync_decoder
    import esync_pkg::*;
#(
    parameter int PIX_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       mode,
    input  logic [PIX_W-1:0] pix_in,
    input  logic             ext_hs,
    input  logic             ext_vs,
    output logic [PIX_W-1:0] pix_out,
    output logic             pix_vld,
    output logic             hs_out,
    output logic             vs_out,
    output logic             field_out,
    output logic             act_out
);
    localparam int DLY_W = PIX_W + 2;

    sync_src_e   src;
    logic        emb;
    logic        cb_slot;
    logic        st_vld;
    trs_status_t st;
    logic        sg_hs, sg_vs, sg_fld, sg_act, sg_vld;
    logic [DLY_W-1:0] dly_out;
    logic        dly_h, dly_v;

    assign src = sync_src_e'(mode);
    assign emb = is_embedded(src);

    esync_slot_phase u_phase (
        .clk(clk), .rst(rst), .src(src), .cb_slot(cb_slot)
    );

    esync_trs_detect u_det (
        .clk(clk), .rst(rst), .en(emb), .cb_slot(cb_slot),
        .lane_byte(pix_in[LANE_W-1:0]), .st_vld(st_vld), .st(st)
    );

    esync_sync_gen #(.LEN(TRS_LEN)) u_gen (
        .clk(clk), .rst(rst), .st_vld(st_vld), .st(st),
        .hs(sg_hs), .vs(sg_vs), .fld(sg_fld), .act(sg_act), .vld(sg_vld)
    );

    esync_delay #(.W(DLY_W), .DEPTH(TRS_LEN)) u_dly (
        .clk(clk), .rst(rst), .din({ext_hs, ext_vs, pix_in}), .dout(dly_out)
    );

    assign dly_h     = dly_out[DLY_W-1];
    assign dly_v     = dly_out[DLY_W-2];
    assign pix_out   = dly_out[PIX_W-1:0];
    assign pix_vld   = sg_vld;
    assign hs_out    = emb ? sg_hs  : dly_h;
    assign vs_out    = emb ? sg_vs  : dly_v;
    assign field_out = emb ? sg_fld : 1'b0;
    assign act_out   = emb ? sg_act : (sg_vld && !(dly_h || dly_v));
endmodule

// File: rtl/esync_decoder_chk.sv
module esync_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode,
    input logic       st_vld,
    input logic       st_eav,
    input logic       st_vblank,
    input logic       pix_vld,
    input logic       hs_out,
    input logic       vs_out,
    input logic       field_out,
    input logic       act_out
);
    logic emb;
    assign emb = (mode == 2'd1) || (mode == 2'd2);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!pix_vld && !hs_out && !vs_out && !field_out && !act_out));

    assert_code_stripped_R3: assert property (@(posedge clk) disable iff (rst)
        st_vld |=> !pix_vld);

    assert_eav_sets_hs_R5: assert property (@(posedge clk) disable iff (rst)
        (emb && st_vld && st_eav) |=> (hs_out && !act_out));

    assert_eav_vblank_R5: assert property (@(posedge clk) disable iff (rst)
        (emb && st_vld && st_eav) |=> (vs_out == $past(st_vblank)));

    assert_sav_clears_hs_R6: assert property (@(posedge clk) disable iff (rst)
        (emb && st_vld && !st_eav) |=> !hs_out);

    assert_active_after_code_R7: assert property (@(posedge clk) disable iff (rst)
        (emb && $rose(act_out)) |-> $past(!pix_vld));

    assert_hold_without_code_R9: assert property (@(posedge clk) disable iff (rst)
        (emb && !st_vld) |=> ((mode != $past(mode)) || ($stable(hs_out) && $stable(vs_out))));

    assert_ext_no_field_R10: assert property (@(posedge clk) disable iff (rst)
        !emb |-> !field_out);
endmodule

bind esync_decoder esync_decoder_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode),
    .st_vld(st_vld), .st_eav(st.eav), .st_vblank(st.vblank),
    .pix_vld(pix_vld), .hs_out(hs_out), .vs_out(vs_out),
    .field_out(field_out), .act_out(act_out)
);

// File: tb/sim_esync_decoder.sv
module sim_esync_decoder;
    localparam int CLK_NS = 10;
    localparam int MAXN   = 1024;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  mode = 2'd0;
    logic [15:0] pix_in = '0;
    logic        ext_hs = 1'b0, ext_vs = 1'b0;
    logic [15:0] pix_out;
    logic        pix_vld, hs_out, vs_out, field_out, act_out;

    always #(CLK_NS/2) clk = ~clk;

    esync_decoder u0 (
        .clk(clk), .rst(rst), .mode(mode), .pix_in(pix_in),
        .ext_hs(ext_hs), .ext_vs(ext_vs), .pix_out(pix_out),
        .pix_vld(pix_vld), .hs_out(hs_out), .vs_out(vs_out),
        .field_out(field_out), .act_out(act_out)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] s_pix [MAXN];
    bit s_eh [MAXN], s_ev [MAXN];
    bit code_at [MAXN], in_code [MAXN];
    bit e_vld [MAXN], e_hs [MAXN], e_vs [MAXN], e_fld [MAXN], e_act [MAXN];
    int n, slot_m;
    bit cur_h, cur_v;
    string seg_tag;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp, input int k);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d: actual %0h expected %0h", req, seg_tag, k, act, exp);
        end
    endtask

    function automatic logic [7:0] safe_byte();
        return 8'($urandom % 255);
    endfunction

    task automatic put(input logic [7:0] lo);
        if (n < MAXN) begin
            if ($urandom % 16 == 0) cur_h = !cur_h;
            if ($urandom % 29 == 0) cur_v = !cur_v;
            s_pix[n] = {8'($urandom), lo};
            s_eh[n]  = cur_h;
            s_ev[n]  = cur_v;
            n++;
        end
    endtask

    task automatic align();
        while (n % slot_m != 0) put(safe_byte());
    endtask

    task automatic put_px(input int cnt);
        for (int i = 0; i < cnt; i++) put(safe_byte());
    endtask

    task automatic put_code(input logic [7:0] s);
        align(); put(8'hFF); put(8'h00); put(8'h00); put(s);
    endtask

    task automatic gen_directed();
        put_px(6); put_code(8'h9D);   // end code, F0 V0, junk low bits (R8)
        put_px(5); put_code(8'h80);   // start code, V0 -> active
        put_px(9); put_code(8'hB0);   // end code, V1
        put_px(3); put_code(8'hA0);   // start code, V1: stays inactive
        put_px(6); put_code(8'h5F);   // end code F1 V0, bit7 clear, low bits set (R8)
        put_px(4); put_code(8'hCA);   // start code F1 V0
        put_px(7);
        align(); put(safe_byte());    // R4: preamble outside a Cb position
        put(8'hFF); put(8'h00); put(8'h00); put(8'h90);
        put_px(5);
        align(); put(8'hFF); put(8'h00); put(8'h33);   // R9: broken after two bytes
        put_px(3);
        align(); put(8'hFF); put(8'h41);               // R9: broken after one byte
        put_px(4);
        put_code(8'h80); put_code(8'h90);              // start then end back to back (R7)
        put_px(6); put_code(8'h80); put_px(8);
    endtask

    task automatic gen_random();
        while (n < MAXN - 40) begin
            case ($urandom % 8)
                0, 1: put_px(1 + $urandom % 12);
                2: put_code(8'($urandom));
                3: begin align(); put(safe_byte()); put(8'hFF); put(8'h00); put(8'h00); put(8'($urandom)); end
                4: begin align(); put(8'hFF); put(8'h00); put(8'($urandom)); end
                5: put(8'($urandom));
                6: put_code(8'h80);
                default: put_code(8'h90 | (8'($urandom) & 8'h60));
            endcase
        end
        put_px(8);
    endtask

    task automatic build_model(input bit emb);
        bit hs, vs, fld, act;
        int pend;
        logic [7:0] s;
        for (int i = 0; i < n; i++) begin code_at[i] = 0; in_code[i] = 0; end
        if (emb) begin
            int i = 0;
            while (i < n) begin
                if (i % slot_m == 0 && i + 3 < n && s_pix[i][7:0] == 8'hFF &&
                    s_pix[i+1][7:0] == 8'h00 && s_pix[i+2][7:0] == 8'h00) begin
                    code_at[i] = 1;
                    for (int q = 0; q < 4; q++) in_code[i+q] = 1;
                    i += 4;
                end else i++;
            end
        end
        hs = 0; vs = 0; fld = 0; act = 0; pend = -1;
        for (int j = 0; j < n; j++) begin
            if (!emb) begin
                e_vld[j] = 1; e_hs[j] = s_eh[j]; e_vs[j] = s_ev[j];
                e_fld[j] = 0; e_act[j] = !(s_eh[j] || s_ev[j]);
            end else begin
                if (pend == j) begin act = 1; pend = -1; end
                if (code_at[j]) begin
                    s = s_pix[j+3][7:0];
                    fld = s[6];
                    if (s[4]) begin hs = 1; vs = s[5]; act = 0; pend = -1; end
                    else begin hs = 0; pend = s[5] ? -1 : j + 4; end
                end
                e_vld[j] = !in_code[j]; e_hs[j] = hs; e_vs[j] = vs;
                e_fld[j] = fld; e_act[j] = act;
            end
        end
    endtask

    task automatic check_reset_state(input int k);
        check("R1 pix_vld", 32'(pix_vld), 0, k);
        check("R1 hs_out", 32'(hs_out), 0, k);
        check("R1 vs_out", 32'(vs_out), 0, k);
        check("R1 field_out", 32'(field_out), 0, k);
        check("R1 act_out", 32'(act_out), 0, k);
        check("R1 pix_out", 32'(pix_out), 0, k);
    endtask

    task automatic run_segment(input logic [1:0] m);
        bit emb;
        emb = (m == 2'd1) || (m == 2'd2);
        build_model(emb);
        @(negedge clk);
        rst = 1'b1; mode = m; pix_in = '0; ext_hs = 0; ext_vs = 0;
        repeat (2) begin @(negedge clk); check_reset_state(-1); end
        for (int k = 0; k < n; k++) begin
            int j;
            if (k > 0) @(negedge clk);
            j = k - 4;
            if (j < 0) check_reset_state(k);
            else begin
                check("R2 pix_out", 32'(pix_out), 32'(s_pix[j]), k);
                check("R3 pix_vld", 32'(pix_vld), 32'(e_vld[j]), k);
                check(emb ? "R5 hs_out" : "R10 hs_out", 32'(hs_out), 32'(e_hs[j]), k);
                check(emb ? "R5 vs_out" : "R10 vs_out", 32'(vs_out), 32'(e_vs[j]), k);
                check(emb ? "R6 field_out" : "R10 field_out", 32'(field_out), 32'(e_fld[j]), k);
                check(emb ? "R7 act_out" : "R10 act_out", 32'(act_out), 32'(e_act[j]), k);
            end
            pix_in = s_pix[k]; ext_hs = s_eh[k]; ext_vs = s_ev[k];
            if (k == 0) rst = 1'b0;
        end
    endtask

    task automatic new_segment(input int m_slots, input string tag);
        n = 0; slot_m = m_slots; cur_h = 0; cur_v = 0; seg_tag = tag;
    endtask

    initial begin
        void'($urandom(32'd20251));
        new_segment(4, "byte mode directed R4 R8 R9");
        gen_directed(); run_segment(2'd1);
        new_segment(2, "16-bit mode directed R4 R8 R9");
        gen_directed(); run_segment(2'd2);
        new_segment(4, "byte mode random");
        gen_random(); run_segment(2'd1);
        new_segment(2, "16-bit mode random");
        gen_random(); run_segment(2'd2);
        new_segment(4, "external sync mode 0 R10");
        gen_random(); run_segment(2'd0);
        new_segment(2, "external sync mode 3 R10");
        gen_random(); run_segment(2'd3);
        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual run still busy, expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule